// File: doc/BRIEF.md
# Extended Register Lock Controller

This block holds three groups of vendor-extended configuration registers behind three indexed I/O port pairs: one pair for the graphics controller, one for the CRT controller and one for the sequencer. Each pair has an index port and a data port at the next address. The index port selects a register inside the group. The data port reads or writes the register that is currently selected.

Each group has a key register at a fixed index. While the key holds its exact unlock value, the group's extended registers act as plain 8-bit read/write storage. Any other key value locks the group. A locked group ignores writes to its extended registers and reads them as 00h. Software can therefore probe for the extensions by writing a pattern and checking whether the same pattern comes back.

A host can load the index and the data in a single 16-bit write to the index port. The index travels in the low byte and the data in the high byte. Read data is registered and held until the next read strobe.

Top module: `xlk_top`

## Requirements
- R1: After reset all three groups are locked, every extended register and index register is 00h, and io_rdata is 00h.
- R2: A byte write to an index port latches the index, and a read of that index port returns it.
- R3: In the graphics group the key is at index 0Fh. The group is unlocked only while the key holds 05h; writing 00h, or any other value, locks it.
- R4: In the CRT group the key is at index 29h. The group (extended indices 2Ah to 30h) is unlocked only while the key holds 85h. While it is locked, writing AAh to index 2Bh does not read back as AAh.
- R5: In the sequencer group the key is at index 06h. The group (extended indices 07h to 14h) is unlocked only while the key holds 48h.
- R6: While a group is locked, a read of one of its extended registers returns 00h, and a write to it leaves the stored value unchanged. The unchanged value can be seen after the group is unlocked.
- R7: While a group is unlocked, each extended register stores all 8 bits. This includes sequencer index 12h bit 6 and sequencer index 10h bit 4, which can each be set and cleared on their own. The graphics window is 09h to 0Eh.
- R8: A 16-bit write to an index port (io_wide=1) loads the index from bits 7:0 and writes bits 15:8 to the newly selected register, all in the same access.
- R9: The key register always reads back the last value written to it, whether the group is locked or not.
- R10: An index that is neither the key nor inside the group's window reads 00h and ignores writes. A read of any address other than the six ports returns 00h.
- R11: io_rdata changes only in the cycle after a read strobe. Without io_rd it holds its value.
- R12: Locking a group hides its registers but keeps their contents. Unlocking it again shows the old values.
- R13: Each group's lock is independent. Unlocking one group leaves the others locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| io_wide | input | 1 | Marks a write as 16-bit (index plus data) |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_rdata | output | 8 | Registered read data, held between reads |

## Verification
The hardest case to reach is proving that a write to a locked register was really dropped. A locked register reads 00h whether or not the write reached storage, so a read while locked shows nothing. The stimulus therefore writes a pattern while the group is locked, then unlocks the group and reads the register, which must still hold its earlier value. It then relocks and unlocks again to show that the contents survive. The word-wide form is mixed into the same sequences, so that an index and data loaded together are shown to hit the new index and not the old one.

// File: rtl/xlk_pkg.sv
package xlk_pkg;
    // number of port pairs / register groups handled by the block
    localparam int NGRP = 3;
    // slot numbers of the groups in every per-group array
    localparam int SLOT_GFX = 0;
    localparam int SLOT_CRT = 1;
    localparam int SLOT_SEQ = 2;

    // bytes carried by one host write after decoding
    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] dat;
    } wr_bytes_t;
endpackage

// File: rtl/xlk_decode.sv
module xlk_decode
    import xlk_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [NGRP-1:0][ADDR_W-1:0] IDX_PORTS = '0
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_wide,
    input  logic [15:0]       io_wdata,
    output logic [NGRP-1:0]   hit_idx,
    output logic [NGRP-1:0]   hit_dat,
    output logic [NGRP-1:0]   idx_wr,
    output logic [NGRP-1:0]   dat_wr,
    output wr_bytes_t         wr_bytes
);
    logic any_idx;

    for (genvar g = 0; g < NGRP; g++) begin : g_port
        always_comb begin
            hit_idx[g] = (io_addr == IDX_PORTS[g]);
            hit_dat[g] = (io_addr == IDX_PORTS[g] + ADDR_W'(1));
            idx_wr[g]  = io_wr & hit_idx[g];
            // a wide write to the index port also carries data
            dat_wr[g]  = io_wr & (hit_dat[g] | (hit_idx[g] & io_wide));
        end
    end

    always_comb begin
        any_idx      = |hit_idx;
        wr_bytes.idx = io_wdata[7:0];
        wr_bytes.dat = (any_idx && io_wide) ? io_wdata[15:8] : io_wdata[7:0];
    end
endmodule

// File: rtl/xlk_bank.sv
module xlk_bank #(
    parameter logic [7:0] KEY_IDX = 8'h0F,
    parameter logic [7:0] KEY_VAL = 8'h05,
    parameter logic [7:0] WIN_LO  = 8'h09,
    parameter int         WIN_CNT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] idx_byte,
    input  logic [7:0] dat_byte,
    output logic [7:0] rd_idx,
    output logic [7:0] rd_dat,
    output logic       open
);
    typedef struct packed {
        logic [7:0]               idx;
        logic [7:0]               key;
        logic [WIN_CNT-1:0][7:0]  regs;
    } bank_t;

    bank_t      st_d, st_q;
    logic [7:0] tgt_idx;

    // next-state logic
    always_comb begin
        st_d    = st_q;
        // a wide write selects and writes in one access
        tgt_idx = idx_wr ? idx_byte : st_q.idx;
        if (idx_wr) begin
            st_d.idx = idx_byte;
        end
        if (dat_wr) begin
            if (tgt_idx == KEY_IDX) begin
                st_d.key = dat_byte;
            end else if (open) begin
                for (int i = 0; i < WIN_CNT; i++) begin
                    if (tgt_idx == 8'(int'(WIN_LO) + i)) begin
                        st_d.regs[i] = dat_byte;
                    end
                end
            end
        end
    end

    // read view of the selected register
    always_comb begin
        open   = (st_q.key == KEY_VAL);
        rd_idx = st_q.idx;
        rd_dat = 8'h00;
        if (st_q.idx == KEY_IDX) begin
            rd_dat = st_q.key;
        end else if (open) begin
            for (int i = 0; i < WIN_CNT; i++) begin
                if (st_q.idx == 8'(int'(WIN_LO) + i)) begin
                    rd_dat = st_q.regs[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xlk_top.sv
module xlk_top
    import xlk_pkg::*;
#(
    parameter int              ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] GFX_PORT  = 10'h3CE,
    parameter logic [ADDR_W-1:0] CRT_PORT  = 10'h3D4,
    parameter logic [ADDR_W-1:0] SEQ_PORT  = 10'h3C4,
    parameter logic [7:0]      GFX_KEY_IDX = 8'h0F,
    parameter logic [7:0]      GFX_KEY_VAL = 8'h05,
    parameter logic [7:0]      GFX_WIN_LO  = 8'h09,
    parameter int              GFX_WIN_CNT = 6,
    parameter logic [7:0]      CRT_KEY_IDX = 8'h29,
    parameter logic [7:0]      CRT_KEY_VAL = 8'h85,
    parameter logic [7:0]      CRT_WIN_LO  = 8'h2A,
    parameter int              CRT_WIN_CNT = 7,
    parameter logic [7:0]      SEQ_KEY_IDX = 8'h06,
    parameter logic [7:0]      SEQ_KEY_VAL = 8'h48,
    parameter logic [7:0]      SEQ_WIN_LO  = 8'h07,
    parameter int              SEQ_WIN_CNT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [15:0]       io_wdata,
    input  logic              io_wide,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata
);
    localparam logic [NGRP-1:0][ADDR_W-1:0] IDX_PORTS = {SEQ_PORT, CRT_PORT, GFX_PORT};
    localparam logic [NGRP-1:0][7:0] KEY_IDXS = {SEQ_KEY_IDX, CRT_KEY_IDX, GFX_KEY_IDX};
    localparam logic [NGRP-1:0][7:0] KEY_VALS = {SEQ_KEY_VAL, CRT_KEY_VAL, GFX_KEY_VAL};
    localparam logic [NGRP-1:0][7:0] WIN_LOS  = {SEQ_WIN_LO, CRT_WIN_LO, GFX_WIN_LO};
    localparam int WIN_CNTS [NGRP] = '{GFX_WIN_CNT, CRT_WIN_CNT, SEQ_WIN_CNT};

    typedef struct packed {
        logic [7:0] rdata;
    } rd_t;

    logic [NGRP-1:0]      hit_idx, hit_dat, idx_wr, dat_wr;
    wr_bytes_t            wr_bytes;
    logic [NGRP-1:0][7:0] bank_idx, bank_dat;
    logic [NGRP-1:0]      grp_open;
    rd_t                  rd_d, rd_q;

    xlk_decode #(
        .ADDR_W    (ADDR_W),
        .IDX_PORTS (IDX_PORTS)
    ) decode_i (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wide  (io_wide),
        .io_wdata (io_wdata),
        .hit_idx  (hit_idx),
        .hit_dat  (hit_dat),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .wr_bytes (wr_bytes)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        xlk_bank #(
            .KEY_IDX (KEY_IDXS[g]),
            .KEY_VAL (KEY_VALS[g]),
            .WIN_LO  (WIN_LOS[g]),
            .WIN_CNT (WIN_CNTS[g])
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx_wr   (idx_wr[g]),
            .dat_wr   (dat_wr[g]),
            .idx_byte (wr_bytes.idx),
            .dat_byte (wr_bytes.dat),
            .rd_idx   (bank_idx[g]),
            .rd_dat   (bank_dat[g]),
            .open     (grp_open[g])
        );
    end

    // read path: sample the pre-write view on a read strobe, hold otherwise
    always_comb begin
        rd_d = rd_q;
        if (io_rd) begin
            rd_d.rdata = 8'h00;
            for (int g = 0; g < NGRP; g++) begin
                if (hit_idx[g]) rd_d.rdata = bank_idx[g];
                if (hit_dat[g]) rd_d.rdata = bank_dat[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign io_rdata = rd_q.rdata;
endmodule

// File: rtl/xlk_chk.sv
module xlk_chk
    import xlk_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] GFX_PORT    = 10'h3CE,
    parameter logic [ADDR_W-1:0] CRT_PORT    = 10'h3D4,
    parameter logic [ADDR_W-1:0] SEQ_PORT    = 10'h3C4,
    parameter logic [7:0]        CRT_WIN_LO  = 8'h2A,
    parameter int                CRT_WIN_CNT = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [7:0]           io_rdata,
    input logic [NGRP-1:0]      grp_open,
    input logic [NGRP-1:0][7:0] bank_idx
);
    logic crt_in_win, foreign_addr;

    always_comb begin
        crt_in_win = (int'(bank_idx[SLOT_CRT]) >= int'(CRT_WIN_LO)) &&
                     (int'(bank_idx[SLOT_CRT]) <  int'(CRT_WIN_LO) + CRT_WIN_CNT);
        foreign_addr = (io_addr != GFX_PORT) && (io_addr != GFX_PORT + ADDR_W'(1)) &&
                       (io_addr != CRT_PORT) && (io_addr != CRT_PORT + ADDR_W'(1)) &&
                       (io_addr != SEQ_PORT) && (io_addr != SEQ_PORT + ADDR_W'(1));
    end

    assert_reset_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (grp_open == '0 && io_rdata == 8'h00));

    assert_lock_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(grp_open));

    assert_locked_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == CRT_PORT + ADDR_W'(1) &&
         !grp_open[SLOT_CRT] && crt_in_win) |=> io_rdata == 8'h00);

    assert_foreign_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && foreign_addr) |=> io_rdata == 8'h00);

    assert_rdata_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
endmodule

bind xlk_top xlk_chk #(
    .ADDR_W      (ADDR_W),
    .GFX_PORT    (GFX_PORT),
    .CRT_PORT    (CRT_PORT),
    .SEQ_PORT    (SEQ_PORT),
    .CRT_WIN_LO  (CRT_WIN_LO),
    .CRT_WIN_CNT (CRT_WIN_CNT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .grp_open (grp_open),
    .bank_idx (bank_idx)
);

// File: tb/xlk_top_tb_top.sv
`timescale 1ns/1ps
module xlk_top_tb_top;
    localparam logic [9:0] GI = 10'h3CE, GD = 10'h3CF;
    localparam logic [9:0] CI = 10'h3D4, CD = 10'h3D5;
    localparam logic [9:0] SI = 10'h3C4, SD = 10'h3C5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic        io_wide = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    xlk_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wide  (io_wide),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_rdata (io_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = {8'h00, d}; io_wide = 1'b0; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wrw(input logic [9:0] a, input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = {d, idx}; io_wide = 1'b1; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_wide = 1'b0;
    endtask

    // driver: issues a read and queues the expected byte
    task automatic rd(input logic [9:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= io_rd;

    // monitor: rdata is valid one edge after the strobe
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("monitor underflow", io_rdata, 8'hxx);
            end else begin
                check(tag_q.pop_front(), io_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rdata after reset", io_rdata, 8'h00);
        rst_n = 1'b1;
        rd(GI, 8'h00, "R1 index cleared");
        rd(GD, 8'h00, "R10 unimplemented index 00");

        // graphics group, locked
        wr(GI, 8'h09);
        rd(GI, 8'h09, "R2 index read back");
        wr(GD, 8'h5A);
        rd(GD, 8'h00, "R6 locked gfx read");
        // unlock with a wide write to the key
        wrw(GI, 8'h0F, 8'h05);
        rd(GD, 8'h05, "R9 key read back");
        rd(GI, 8'h0F, "R8 wide write set index");
        wr(GI, 8'h09);
        rd(GD, 8'h00, "R6 locked write dropped");
        wr(GD, 8'h5A);
        rd(GD, 8'h5A, "R7 gfx stores byte");
        wrw(GI, 8'h0E, 8'hC3);
        rd(GD, 8'hC3, "R8 wide data to new index");
        // wrong key locks
        wrw(GI, 8'h0F, 8'h04);
        rd(GD, 8'h04, "R9 key read back while locked");
        wr(GI, 8'h09);
        rd(GD, 8'h00, "R3 wrong key locks");
        wrw(GI, 8'h0F, 8'h00);
        wrw(GI, 8'h0F, 8'h05);
        wr(GI, 8'h09);
        rd(GD, 8'h5A, "R12 contents kept over relock");
        wrw(GI, 8'h0F, 8'h00);
        wr(GI, 8'h0E);
        rd(GD, 8'h00, "R3 key 00h locks");

        // CRT group
        wr(CI, 8'h2B);
        wr(CD, 8'hAA);
        rd(CD, 8'h00, "R4 locked 2Bh not AAh");
        wrw(CI, 8'h29, 8'h85);
        rd(CI, 8'h29, "R2 crt index");
        wr(CI, 8'h2B);
        rd(CD, 8'h00, "R6 locked AAh dropped");
        wr(CD, 8'hAA);
        rd(CD, 8'hAA, "R4 unlocked 2Bh stores AAh");
        wrw(CI, 8'h30, 8'h3C);
        rd(CD, 8'h3C, "R4 window top 30h");
        wrw(CI, 8'h05, 8'h77);
        rd(CD, 8'h00, "R10 outside window");
        wrw(CI, 8'h31, 8'h77);
        rd(CD, 8'h00, "R10 past window end");
        wrw(CI, 8'h29, 8'h84);
        wr(CI, 8'h2B);
        rd(CD, 8'h00, "R4 near key locks");

        // sequencer group stays locked while others change
        wrw(SI, 8'h12, 8'h40);
        rd(SD, 8'h00, "R13 seq still locked");
        wrw(SI, 8'h06, 8'h48);
        wr(SI, 8'h12);
        rd(SD, 8'h00, "R6 locked seq write dropped");
        wrw(SI, 8'h12, 8'h40);
        rd(SD, 8'h40, "R7 seq 12h bit6 set");
        wrw(SI, 8'h12, 8'h00);
        rd(SD, 8'h00, "R7 seq 12h bit6 clear");
        wrw(SI, 8'h10, 8'h10);
        rd(SD, 8'h10, "R7 seq 10h bit4 set");
        wr(SI, 8'h12);
        rd(SD, 8'h00, "R7 12h independent of 10h");
        wrw(SI, 8'h07, 8'hE1);
        rd(SD, 8'hE1, "R5 window base 07h");
        wr(SI, 8'h06);
        rd(SD, 8'h48, "R5 key read back");
        wrw(GI, 8'h0F, 8'h05);
        wr(GI, 8'h0E);
        rd(GD, 8'hC3, "R13 gfx unlock leaves seq data");
        wrw(SI, 8'h06, 8'h00);
        wr(SI, 8'h10);
        rd(SD, 8'h00, "R5 seq relocked");

        // foreign address and read hold
        rd(10'h3C0, 8'h00, "R10 foreign address");
        wr(SI, 8'h06);
        rd(SD, 8'h00, "R11 key value 00h");
        rd(CD, 8'h00, "R11 pre-hold");
        wr(GI, 8'h0F);
        rd(GD, 8'h05, "R11 load 05h");
        repeat (4) @(negedge clk);
        check("R11 rdata held without strobe", io_rdata, 8'h05);

        repeat (3) @(negedge clk);
        check("queue drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule